// File: doc/BRIEF.md
# Mailbox Command Sequencer Master

This block carries out indirect register accesses through a two-register command mailbox. Upstream logic hands it one request at a time: a target address, a direction, a choice between the CSR space and the MMIO space, write data, and, for read-modify-write requests, an AND mask. The block turns each request into a fixed chain of four mailbox commands. These are open, register address, data and close. It issues them as 32-bit accesses on a simple register-bus master port.

Each mailbox command is launched the same way. The payload goes into the data register first. Then the interface register is written with the run/busy bit and the opcode. The interface register is then polled, with an idle gap between polls, until the busy bit drops. An attempt that stays busy for too long, or that completes with a response code other than success, is retried a bounded number of times. If all attempts fail, the error flag of the request is raised and the chain moves on to the next command. After the data command, the data register is read back and returned. A read-modify-write request runs a complete read chain. It then runs a complete write chain whose payload is the read value ANDed with the mask and ORed with the request's write data.

Top module: `mbx_seq_master`

## Requirements
- R1: Every request issues open, register, data and close, in that order. The open and close payload is the sequence ID: 1 for CSR read, 2 for CSR write, 3 for MMIO read, 4 for MMIO write. The opcodes are 0x02 for open and 0x03 for close. The register command uses 0x13 for CSR read, 0x14 for CSR write, 0x15 for MMIO read and 0x16 for MMIO write, with the address as payload. The data command uses 0x07 for reads with payload zero, and 0x08 for writes with the write value as payload.
- R2: Each attempt first writes its payload to the data register at offset 0x6c04. It then writes the interface register at offset 0x6c00 with bit 31 set and the opcode in bits 7:0. Opcode 0x00 is never written.
- R3: A poll that returns bit 31 set is followed, after GAP_CYCLES idle cycles, by the next poll. An attempt reads the interface register at most POLL_LIMIT times. If bit 31 is still set on the last read, the attempt fails.
- R4: An attempt succeeds only when a poll returns bit 31 clear and bits 15:0 equal to 0x0040. Any other completion causes a retry. A command is attempted at most RETRY_LIMIT times.
- R5: When all attempts of a command fail, rsp_error is set for that request and the chain continues with the next command.
- R6: After the data command and before close, the data register is read once. For read and write requests, rsp_rdata carries that value.
- R7: A read-modify-write request (req_rmw=1) runs a full read chain and then a full write chain in the same space. The write value is (read value AND req_mask) OR req_wdata. rsp_rdata carries the value from the read chain.
- R8: A request is taken when req_valid and req_ready are both high. req_ready stays low until the response has been taken. rsp_valid, rsp_rdata and rsp_error hold steady until rsp_ready.
- R9: On the bus port, address, direction and write data stay stable while bus_req is high and bus_ack is low. No bus access is made while a response is pending.
- R10: After reset, req_ready is 1 and both rsp_valid and bus_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken this cycle if valid |
| req_addr | input | 32 | Target register address |
| req_write | input | 1 | 1 = write, 0 = read (ignored when req_rmw) |
| req_mmio | input | 1 | 1 = MMIO space, 0 = CSR space |
| req_rmw | input | 1 | Read-modify-write request |
| req_wdata | input | 32 | Write value, or OR-set value for read-modify-write |
| req_mask | input | 32 | AND mask for read-modify-write |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Data register value after the data command |
| rsp_error | output | 1 | At least one command exhausted its attempts |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | BUS_AW | Mailbox register offset |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus access complete |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |

## Verification
The assertions are checked on every cycle. They cover bus request stability, the restriction of addresses to the two mailbox offsets, and the launch word carrying the busy bit and a non-zero opcode. They also check that each launch is preceded by a data-register write, and that the response is held and a new request is blocked. Only the bench scenarios can show the rest, because it depends on what the mailbox answers. That includes the opcode and payload chain for each space and direction, and the exact poll counts and poll spacing. It also includes retry counts under injected bad responses, continuation after a command exhausts its attempts, and the merged value of a read-modify-write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DW = 32;
    localparam logic [15:0] RESP_OK = 16'h0040;

    typedef enum logic [7:0] {
        OP_NONE    = 8'h00,
        OP_OPEN    = 8'h02,
        OP_CLOSE   = 8'h03,
        OP_RD_DATA = 8'h07,
        OP_WR_DATA = 8'h08,
        OP_RD_CSR  = 8'h13,
        OP_WR_CSR  = 8'h14,
        OP_RD_MMIO = 8'h15,
        OP_WR_MMIO = 8'h16
    } mbx_op_e;

    typedef enum logic [2:0] {
        E_IDLE, E_WDATA, E_WIFC, E_POLL, E_GAP, E_FETCH, E_DONE
    } eng_st_e;

    typedef enum logic [2:0] {
        C_IDLE, C_OPEN, C_REG, C_DATA, C_FETCH, C_CLOSE, C_RESP
    } ctl_st_e;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic          write;
        logic          mmio;
        logic          rmw;
        logic [DW-1:0] wdata;
        logic [DW-1:0] mask;
    } mbx_req_t;

    function automatic logic [2:0] seq_id(input logic is_wr, input logic mmio);
        return mmio ? (is_wr ? 3'd4 : 3'd3) : (is_wr ? 3'd2 : 3'd1);
    endfunction

    function automatic mbx_op_e reg_op(input logic is_wr, input logic mmio);
        if (mmio) return is_wr ? OP_WR_MMIO : OP_RD_MMIO;
        return is_wr ? OP_WR_CSR : OP_RD_CSR;
    endfunction

    function automatic mbx_op_e data_op(input logic is_wr);
        return is_wr ? OP_WR_DATA : OP_RD_DATA;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                            input logic [DW-1:0] mask,
                                            input logic [DW-1:0] set);
        return (old & mask) | set;
    endfunction

endpackage

// File: rtl/mbx_cmd_engine.sv
module mbx_cmd_engine
    import mbx_pkg::*;
#(
    parameter int            BUS_AW      = 16,
    parameter logic [BUS_AW-1:0] IFC_OFS = 16'h6c00,
    parameter logic [BUS_AW-1:0] DATA_OFS = 16'h6c04,
    parameter int            POLL_LIMIT  = 100,
    parameter int            RETRY_LIMIT = 10,
    parameter int            GAP_CYCLES  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              fetch,
    input  mbx_op_e           opcode,
    input  logic [DW-1:0]     payload,
    output logic              done,
    output logic              fail,
    output logic [DW-1:0]     fetched,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [DW-1:0]     bus_wdata,
    input  logic              bus_ack,
    input  logic [DW-1:0]     bus_rdata
);

    localparam int PW = $clog2(POLL_LIMIT + 1);
    localparam int TW = $clog2(RETRY_LIMIT + 1);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    eng_st_e       st;
    mbx_op_e       op_r;
    logic [DW-1:0] pay_r;
    logic [PW-1:0] polls;
    logic [TW-1:0] tries;
    logic [GW-1:0] gap;

    logic          busy_seen;
    logic          att_bad;
    logic          last_try;
    logic [DW-1:0] launch_word;

    assign busy_seen   = bus_rdata[DW-1];
    assign last_try    = (tries == TW'(RETRY_LIMIT - 1));
    assign att_bad     = (st == E_POLL) && bus_ack &&
                         (busy_seen ? (polls == PW'(POLL_LIMIT - 1))
                                    : (bus_rdata[15:0] != RESP_OK));
    assign launch_word = {1'b1, {(DW-9){1'b0}}, op_r};

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= E_IDLE;
            op_r    <= OP_NONE;
            pay_r   <= '0;
            polls   <= '0;
            tries   <= '0;
            gap     <= '0;
            fail    <= 1'b0;
            fetched <= '0;
        end else begin
            case (st)
                E_IDLE: if (start) begin
                    op_r  <= opcode;
                    pay_r <= payload;
                    tries <= '0;
                    fail  <= 1'b0;
                    st    <= fetch ? E_FETCH : E_WDATA;
                end
                E_WDATA: if (bus_ack) st <= E_WIFC;
                E_WIFC: if (bus_ack) begin
                    polls <= '0;
                    st    <= E_POLL;
                end
                E_POLL: if (bus_ack) begin
                    if (att_bad) begin
                        if (last_try) begin
                            fail <= 1'b1;
                            st   <= E_DONE;
                        end else begin
                            tries <= tries + 1'b1;
                            st    <= E_WDATA;
                        end
                    end else if (busy_seen) begin
                        polls <= polls + 1'b1;
                        gap   <= '0;
                        st    <= E_GAP;
                    end else begin
                        st <= E_DONE;
                    end
                end
                E_GAP: begin
                    if (gap == GW'(GAP_CYCLES - 1)) st <= E_POLL;
                    else gap <= gap + 1'b1;
                end
                E_FETCH: if (bus_ack) begin
                    fetched <= bus_rdata;
                    st      <= E_DONE;
                end
                E_DONE: st <= E_IDLE;
                default: st <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = (st == E_WDATA) || (st == E_WIFC) || (st == E_POLL) || (st == E_FETCH);
        bus_we    = (st == E_WDATA) || (st == E_WIFC);
        bus_addr  = ((st == E_WDATA) || (st == E_FETCH)) ? DATA_OFS : IFC_OFS;
        bus_wdata = (st == E_WDATA) ? pay_r : (st == E_WIFC) ? launch_word : '0;
    end

    assign done = (st == E_DONE);

endmodule

// File: rtl/mbx_seq_ctrl.sv
module mbx_seq_ctrl
    import mbx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  mbx_req_t      req_in,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_error,
    output logic          eng_start,
    output logic          eng_fetch,
    output mbx_op_e       eng_op,
    output logic [DW-1:0] eng_payload,
    input  logic          eng_done,
    input  logic          eng_fail,
    input  logic [DW-1:0] eng_fetched
);

    ctl_st_e       st;
    mbx_req_t      r;
    logic          phase;
    logic          launched;
    logic          err;
    logic [DW-1:0] rd_cap;

    logic          is_wr;
    logic          in_step;
    logic [2:0]    sid;
    logic [DW-1:0] wval;

    assign is_wr   = r.rmw ? phase : r.write;
    assign sid     = seq_id(is_wr, r.mmio);
    assign wval    = r.rmw ? merge(rd_cap, r.mask, r.wdata) : r.wdata;
    assign in_step = (st == C_OPEN) || (st == C_REG) || (st == C_DATA) ||
                     (st == C_FETCH) || (st == C_CLOSE);

    always_comb begin
        eng_start   = in_step && !launched;
        eng_fetch   = (st == C_FETCH);
        eng_op      = OP_NONE;
        eng_payload = '0;
        case (st)
            C_OPEN:  begin eng_op = OP_OPEN;             eng_payload = {{(DW-3){1'b0}}, sid}; end
            C_REG:   begin eng_op = reg_op(is_wr, r.mmio); eng_payload = r.addr; end
            C_DATA:  begin eng_op = data_op(is_wr);      eng_payload = is_wr ? wval : '0; end
            C_CLOSE: begin eng_op = OP_CLOSE;            eng_payload = {{(DW-3){1'b0}}, sid}; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= C_IDLE;
            r        <= '0;
            phase    <= 1'b0;
            launched <= 1'b0;
            err      <= 1'b0;
            rd_cap   <= '0;
        end else begin
            case (st)
                C_IDLE: if (req_valid) begin
                    r     <= req_in;
                    phase <= 1'b0;
                    err   <= 1'b0;
                    st    <= C_OPEN;
                end
                C_RESP: if (rsp_ready) st <= C_IDLE;
                default: begin
                    if (eng_start) launched <= 1'b1;
                    if (eng_done) begin
                        launched <= 1'b0;
                        if (eng_fail) err <= 1'b1;
                        case (st)
                            C_OPEN:  st <= C_REG;
                            C_REG:   st <= C_DATA;
                            C_DATA:  st <= C_FETCH;
                            C_FETCH: begin
                                if (!(r.rmw && phase)) rd_cap <= eng_fetched;
                                st <= C_CLOSE;
                            end
                            C_CLOSE: begin
                                if (r.rmw && !phase) begin
                                    phase <= 1'b1;
                                    st    <= C_OPEN;
                                end else begin
                                    st <= C_RESP;
                                end
                            end
                            default: st <= C_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    assign req_ready = (st == C_IDLE);
    assign rsp_valid = (st == C_RESP);
    assign rsp_rdata = rd_cap;
    assign rsp_error = err;

endmodule

// File: rtl/mbx_seq_master.sv
module mbx_seq_master
    import mbx_pkg::*;
#(
    parameter int            BUS_AW      = 16,
    parameter logic [BUS_AW-1:0] IFC_OFS = 16'h6c00,
    parameter logic [BUS_AW-1:0] DATA_OFS = 16'h6c04,
    parameter int            POLL_LIMIT  = 100,
    parameter int            RETRY_LIMIT = 10,
    parameter int            GAP_CYCLES  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic              req_write,
    input  logic              req_mmio,
    input  logic              req_rmw,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       req_mask,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_error,
    output logic              bus_req,
    output logic              bus_we,
    output logic [BUS_AW-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic              bus_ack,
    input  logic [31:0]       bus_rdata
);

    mbx_req_t      req_in;
    logic          eng_start;
    logic          eng_fetch;
    mbx_op_e       eng_op;
    logic [DW-1:0] eng_payload;
    logic          eng_done;
    logic          eng_fail;
    logic [DW-1:0] eng_fetched;

    always_comb begin
        req_in.addr  = req_addr;
        req_in.write = req_write;
        req_in.mmio  = req_mmio;
        req_in.rmw   = req_rmw;
        req_in.wdata = req_wdata;
        req_in.mask  = req_mask;
    end

    mbx_seq_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_in      (req_in),
        .rsp_valid   (rsp_valid),
        .rsp_ready   (rsp_ready),
        .rsp_rdata   (rsp_rdata),
        .rsp_error   (rsp_error),
        .eng_start   (eng_start),
        .eng_fetch   (eng_fetch),
        .eng_op      (eng_op),
        .eng_payload (eng_payload),
        .eng_done    (eng_done),
        .eng_fail    (eng_fail),
        .eng_fetched (eng_fetched)
    );

    mbx_cmd_engine #(
        .BUS_AW      (BUS_AW),
        .IFC_OFS     (IFC_OFS),
        .DATA_OFS    (DATA_OFS),
        .POLL_LIMIT  (POLL_LIMIT),
        .RETRY_LIMIT (RETRY_LIMIT),
        .GAP_CYCLES  (GAP_CYCLES)
    ) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (eng_start),
        .fetch     (eng_fetch),
        .opcode    (eng_op),
        .payload   (eng_payload),
        .done      (eng_done),
        .fail      (eng_fail),
        .fetched   (eng_fetched),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

endmodule

// File: rtl/mbx_seq_master_chk.sv
module mbx_seq_master_chk #(
    parameter int            BUS_AW   = 16,
    parameter logic [BUS_AW-1:0] IFC_OFS  = 16'h6c00,
    parameter logic [BUS_AW-1:0] DATA_OFS = 16'h6c04
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_error,
    input logic              bus_req,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ack
);

    logic last_wr_data;

    always_ff @(posedge clk) begin
        if (rst) last_wr_data <= 1'b0;
        else if (bus_req && bus_ack && bus_we) last_wr_data <= (bus_addr == DATA_OFS);
    end

    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

    // R2
    bus_addr_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_addr == IFC_OFS) || (bus_addr == DATA_OFS));

    // R2
    launch_word_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && (bus_addr == IFC_OFS) |-> bus_wdata[31] && (bus_wdata[7:0] != 8'h00));

    // R2
    data_first_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && (bus_addr == IFC_OFS) |-> last_wr_data);

    // R8
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_error));

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R9
    quiet_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !bus_req);

endmodule

bind mbx_seq_master mbx_seq_master_chk #(
    .BUS_AW   (BUS_AW),
    .IFC_OFS  (IFC_OFS),
    .DATA_OFS (DATA_OFS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rsp_error (rsp_error),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack)
);

// File: tb/sim_mbx_seq_master.sv
module sim_mbx_seq_master;

    localparam int CLK_PERIOD = 10;
    localparam int GAP   = 3;
    localparam int POLLS = 5;
    localparam int TRIES = 3;
    localparam logic [15:0] A_IFC  = 16'h6c00;
    localparam logic [15:0] A_DATA = 16'h6c04;

    typedef struct packed {
        logic        wr;
        logic        mm;
        logic        rmw;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [31:0] mask;
        logic [3:0]  busy;
        logic [3:0]  inj;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 4'd2, 32'hA5A5_0001, 32'h0,         4'd0, 4'd0},
        '{1'b0, 1'b0, 1'b0, 4'd2, 32'h0,         32'h0,         4'd1, 4'd0},
        '{1'b1, 1'b1, 1'b0, 4'd2, 32'h1234_5678, 32'h0,         4'd4, 4'd0},
        '{1'b0, 1'b1, 1'b0, 4'd2, 32'h0,         32'h0,         4'd0, 4'd0},
        '{1'b0, 1'b0, 1'b0, 4'd2, 32'h0,         32'h0,         4'd0, 4'd2},
        '{1'b1, 1'b0, 1'b0, 4'd7, 32'hDEAD_BEEF, 32'h0,         4'd0, 4'd3},
        '{1'b0, 1'b0, 1'b1, 4'd7, 32'h0000_00AA, 32'hFFFF_0000, 4'd0, 4'd0},
        '{1'b0, 1'b0, 1'b0, 4'd7, 32'h0,         32'h0,         4'd0, 4'd0},
        '{1'b0, 1'b1, 1'b1, 4'd2, 32'hAB00_0000, 32'h0000_FFFF, 4'd2, 4'd0},
        '{1'b0, 1'b1, 1'b0, 4'd2, 32'h0,         32'h0,         4'd0, 4'd0},
        '{1'b0, 1'b0, 1'b0, 4'd9, 32'h0,         32'h0,         4'd0, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_mmio = 1'b0;
    logic        req_rmw = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_mask = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_rdata;
    logic        rsp_error;
    logic        bus_req;
    logic        bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack;
    logic [31:0] bus_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_seq_master #(
        .BUS_AW(16), .IFC_OFS(A_IFC), .DATA_OFS(A_DATA),
        .POLL_LIMIT(POLLS), .RETRY_LIMIT(TRIES), .GAP_CYCLES(GAP)
    ) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_mmio(req_mmio),
        .req_rmw(req_rmw), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .rsp_error(rsp_error),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // ---------------- mailbox target model ----------------
    int          k_busy = 0;
    int          k_inj = 0;
    int          k_stuck = 0;
    logic        mdl_clear = 1'b0;

    logic [31:0] dreg;
    logic [31:0] mem_c [16];
    logic [31:0] mem_m [16];
    logic [7:0]  cur_op;
    logic [3:0]  cur_addr;
    logic        cur_mm;
    logic [15:0] resp_cur;
    logic        pend;
    logic        data_seen;
    logic        last_busy;
    int          busy_left;
    int          lcount;
    int          ifc_reads;
    int          order_bad;
    int          gap_bad;
    int          cyc;
    int          last_poll;
    int          log_n;
    logic [7:0]  log_op  [32];
    logic [31:0] log_pay [32];

    initial begin
        for (int i = 0; i < 16; i++) begin mem_c[i] = '0; mem_m[i] = '0; end
        bus_ack = 1'b0; bus_rdata = '0; dreg = '0; cyc = 0;
        busy_left = 0; lcount = 0; ifc_reads = 0; order_bad = 0; gap_bad = 0;
        log_n = 0; pend = 1'b0; data_seen = 1'b0; last_busy = 1'b0; last_poll = 0;
        cur_op = '0; cur_addr = '0; cur_mm = 1'b0; resp_cur = '0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mdl_clear) begin
            lcount <= 0; ifc_reads <= 0; order_bad <= 0; gap_bad <= 0;
            log_n <= 0; last_busy <= 1'b0; bus_ack <= 1'b0; data_seen <= 1'b0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                if (bus_addr == A_DATA) begin
                    dreg <= bus_wdata;
                    data_seen <= 1'b1;
                end else begin
                    if (!data_seen || !bus_wdata[31] || bus_wdata[7:0] == 8'h00)
                        order_bad <= order_bad + 1;
                    data_seen <= 1'b0;
                    last_busy <= 1'b0;
                    cur_op    <= bus_wdata[7:0];
                    busy_left <= (lcount < k_stuck) ? 1000 : k_busy;
                    resp_cur  <= (lcount < k_inj) ? 16'h0090 : 16'h0040;
                    pend      <= 1'b1;
                    lcount    <= lcount + 1;
                end
            end else if (bus_addr == A_DATA) begin
                bus_rdata <= dreg;
            end else begin
                ifc_reads <= ifc_reads + 1;
                if (last_busy && (cyc - last_poll != GAP + 2)) gap_bad <= gap_bad + 1;
                last_poll <= cyc;
                if (busy_left > 0) begin
                    busy_left <= busy_left - 1;
                    bus_rdata <= 32'h8000_0080;
                    last_busy <= 1'b1;
                end else begin
                    last_busy <= 1'b0;
                    bus_rdata <= {16'h0, resp_cur};
                    pend <= 1'b0;
                    if (pend && resp_cur == 16'h0040) begin
                        log_op[log_n]  <= cur_op;
                        log_pay[log_n] <= dreg;
                        log_n <= log_n + 1;
                        case (cur_op)
                            8'h13, 8'h14, 8'h15, 8'h16: begin
                                cur_addr <= dreg[3:0];
                                cur_mm   <= (cur_op == 8'h15) || (cur_op == 8'h16);
                            end
                            8'h07: dreg <= cur_mm ? mem_m[cur_addr] : mem_c[cur_addr];
                            8'h08: if (cur_mm) mem_m[cur_addr] <= dreg;
                                   else        mem_c[cur_addr] <= dreg;
                            default: ;
                        endcase
                    end
                end
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] ref_c [16];
    logic [31:0] ref_m [16];
    logic [7:0]  exp_op  [32];
    logic [31:0] exp_pay [32];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(input vec_t v, input int stuck);
        int nph, a0, exp_n, exp_l, exp_reads;
        logic first_ok, exp_err;
        logic [31:0] old, exp_rd, wv;
        k_busy = int'(v.busy); k_inj = int'(v.inj); k_stuck = stuck;
        @(negedge clk); mdl_clear = 1'b1;
        @(negedge clk); mdl_clear = 1'b0;
        old = v.mm ? ref_m[v.addr] : ref_c[v.addr];
        nph = v.rmw ? 2 : 1;
        first_ok = (int'(v.inj) < TRIES) && (stuck < TRIES);
        exp_err  = !first_ok;
        a0 = (stuck >= TRIES) ? TRIES : (int'(v.inj) >= TRIES ? TRIES : int'(v.inj) + 1);
        exp_l = nph * 4 - 1 + a0;
        exp_reads = (exp_l - ((stuck >= TRIES) ? TRIES : 0)) * (int'(v.busy) + 1)
                    + ((stuck >= TRIES) ? TRIES * POLLS : 0);
        exp_n = 0;
        for (int ph = 0; ph < nph; ph++) begin
            logic w; logic [31:0] sid;
            w = v.rmw ? (ph == 1) : v.wr;
            sid = v.mm ? (w ? 32'd4 : 32'd3) : (w ? 32'd2 : 32'd1);
            wv = v.rmw ? ((old & v.mask) | v.wdata) : v.wdata;
            if (!(ph == 0 && !first_ok)) begin exp_op[exp_n] = 8'h02; exp_pay[exp_n] = sid; exp_n++; end
            exp_op[exp_n] = v.mm ? (w ? 8'h16 : 8'h15) : (w ? 8'h14 : 8'h13);
            exp_pay[exp_n] = {28'h0, v.addr}; exp_n++;
            exp_op[exp_n] = w ? 8'h08 : 8'h07; exp_pay[exp_n] = w ? wv : 32'h0; exp_n++;
            exp_op[exp_n] = 8'h03; exp_pay[exp_n] = sid; exp_n++;
        end
        exp_rd = (v.wr && !v.rmw) ? v.wdata : old;
        if (v.rmw) begin
            if (v.mm) ref_m[v.addr] = (old & v.mask) | v.wdata;
            else      ref_c[v.addr] = (old & v.mask) | v.wdata;
        end else if (v.wr) begin
            if (v.mm) ref_m[v.addr] = v.wdata; else ref_c[v.addr] = v.wdata;
        end

        req_addr = {28'h0, v.addr}; req_write = v.wr; req_mmio = v.mm;
        req_rmw = v.rmw; req_wdata = v.wdata; req_mask = v.mask; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 ready low after accept", {31'h0, req_ready}, 32'h0);
        while (!rsp_valid) @(negedge clk);
        chk(rsp_rdata == exp_rd, "R6/R7 rsp_rdata", rsp_rdata, exp_rd);
        chk(rsp_error == exp_err, "R5 rsp_error", {31'h0, rsp_error}, {31'h0, exp_err});
        chk(lcount == exp_l, "R4 launch count", lcount, exp_l);
        chk(ifc_reads == exp_reads, "R3 poll reads", ifc_reads, exp_reads);
        chk(order_bad == 0, "R2 data-before-launch order", order_bad, 0);
        chk(gap_bad == 0, "R3 poll spacing", gap_bad, 0);
        chk(log_n == exp_n, "R1 completed command count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(log_op[i] == exp_op[i], "R1 opcode order", {24'h0, log_op[i]}, {24'h0, exp_op[i]});
            chk(log_pay[i] == exp_pay[i], "R1 payload", log_pay[i], exp_pay[i]);
        end
        @(negedge clk); @(negedge clk);
        chk(rsp_valid && rsp_rdata == exp_rd, "R8 response held", rsp_rdata, exp_rd);
        chk(!bus_req, "R9 bus quiet while response pending", {31'h0, bus_req}, 32'h0);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready && !rsp_valid, "R8 idle after response taken", {31'h0, rsp_valid}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin ref_c[i] = '0; ref_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(req_ready == 1'b1, "R10 req_ready", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R10 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk(bus_req == 1'b0, "R10 bus_req", {31'h0, bus_req}, 32'h0);

        for (int i = 0; i < NV; i++) run_req(VECS[i], 0);

        // R3/R5: open stays busy past the poll limit on every attempt
        run_req('{1'b1, 1'b0, 1'b0, 4'd15, 32'h5555_AAAA, 32'h0, 4'd0, 4'd0}, TRIES);
        // R7: read-modify-write where the read chain hits retries
        run_req('{1'b0, 1'b0, 1'b1, 4'd15, 32'h0000_0F00, 32'h00FF_00FF, 4'd1, 4'd1}, 0);
        run_req('{1'b0, 1'b0, 1'b0, 4'd15, 32'h0, 32'h0, 4'd0, 4'd0}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule